// File: doc/BRIEF.md
# Conversion Mode Sequencer with Status

This block is the control core of a two-channel capacitance converter. It takes a small configuration word that holds a 3-bit operating mode and one enable bit per channel. From that word it schedules conversions on the enabled channels. The length of each conversion is set by a 2-bit oversampling selector, scaled to a parameterized number of clock cycles per millisecond. The analog front end is modelled by three signals: a busy indication, a "time elapsed" request, and a done strobe that carries a 12-bit raw code.

Finished results are stored left-aligned in a 16-bit data register for the channel that produced them, and the block keeps a status byte. In the status byte each channel has an active-low ready flag, one bit records which channel converted last, and one bit flags power-down or low supply. The two calibration modes run as ordinary conversions. Their result goes into the channel's offset or gain coefficient register instead of the data register. A result that completes while a serial read is in progress is discarded. Single-shot modes write the mode field back to idle once every enabled channel has been converted.

Top module: `conv_sequencer`

## Requirements
- R1: After synchronous reset the status byte reads 0x03, both data registers read 0x0000, both offset and gain coefficients read 0x8000, and the configuration readback reads 0x00.
- R2: The mode field is bits [2:0] of the configuration word: 001 continuous, 010 single, 101 offset calibration and 110 gain calibration start conversions. 000 (idle), 011 (power-down) and the unused codes 100 and 111 start none.
- R3: Configuration bit 4 enables channel 1 and bit 3 enables channel 2. With neither bit set no conversion starts, and a conversion only ever runs on an enabled channel.
- R4: A conversion's counting phase (afe_busy high, afe_due low) lasts OSR_MS[osr_sel] x CYC_PER_MS cycles, with 00 = 5 ms, 01 = 20 ms, 10 = 50 ms and 11 = 60 ms.
- R5: In continuous mode with both channels enabled, conversions alternate channel 1, channel 2, channel 1, and so on. With one channel enabled, that channel repeats.
- R6: Single conversion and both calibrations convert each enabled channel once, channel 1 first. After that the mode field reads 000 and no further conversion starts.
- R7: A kept data result loads {code, 4'b0000} into that channel's data register. It clears that channel's ready bit (status bit 0 for channel 1, bit 1 for channel 2) to 0 and sets status bit 2 to the channel (0 = channel 1, 1 = channel 2).
- R8: A data result whose done strobe arrives while rd_busy is high is discarded: the data registers, the ready bits and status bit 2 stay unchanged.
- R9: A pulse on rd_hi_strobe[n] (the high byte of channel n+1 being read) returns that channel's ready bit to 1.
- R10: Offset calibration drives afe_zero high during its conversion and loads {code, 4'b0000} into the channel's offset coefficient. Gain calibration keeps afe_zero low and loads the gain coefficient. Neither touches data registers or ready bits.
- R11: Status bit 7 is 1 while the mode is 011 or low_supply is high, and bits 6:3 read 0. Writing mode 011 aborts a conversion in flight: afe_busy drops on the next cycle, and a later done strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word: [4] ch1 enable, [3] ch2 enable, [2:0] mode |
| cfg_rdata | output | 5 | Configuration readback, same layout |
| osr_sel | input | 2 | Conversion time selector |
| low_supply | input | 1 | Low-supply flag from the supply monitor |
| rd_busy | input | 1 | Serial read in progress (until the stop condition) |
| rd_hi_strobe | input | 2 | Per-channel pulse: data high byte read |
| afe_done | input | 1 | Front end result strobe |
| afe_code | input | CODE_W | Raw result code |
| afe_busy | output | 1 | A conversion is counting or waiting for its result |
| afe_due | output | 1 | Conversion time elapsed, result awaited |
| afe_chan | output | 1 | Channel being converted (0 = ch1) |
| afe_zero | output | 1 | Apply zero-scale input (offset calibration) |
| status_byte | output | 8 | Status: [7] power-down, [2] last channel, [1:0] ready_n |
| ch1_data | output | DATA_W | Channel 1 result |
| ch2_data | output | DATA_W | Channel 2 result |
| ch1_offset | output | DATA_W | Channel 1 offset coefficient |
| ch2_offset | output | DATA_W | Channel 2 offset coefficient |
| ch1_gain | output | DATA_W | Channel 1 gain coefficient |
| ch2_gain | output | DATA_W | Channel 2 gain coefficient |

## Verification
A table walks single conversions through all four oversampling codes on alternating channels with distinct raw codes. This tells a wrong duration, a swapped channel or a misaligned result apart, since each entry pins down cycle count, channel and data value together. Continuous runs with both channels and with channel 2 alone separate true alternation from a stuck channel. Single-shot and calibration runs show the write-back to idle and that coefficients, not data, are loaded. Directed cases cover the unused and idle mode codes, no enables, a result landing during a serial read, and power-down arriving mid-conversion; each of these must leave every register unchanged.

// File: rtl/cseq_pkg.sv
// Package: shared mode codes, conversion kinds and sequencer states.
// Assumes the 3-bit mode field layout of the configuration word.
package cseq_pkg;

    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_CONT  = 3'b001;
    localparam logic [2:0] MODE_SINGL = 3'b010;
    localparam logic [2:0] MODE_PDOWN = 3'b011;
    localparam logic [2:0] MODE_OFCAL = 3'b101;
    localparam logic [2:0] MODE_GNCAL = 3'b110;

    localparam int CFG_EN1_BIT = 4;
    localparam int CFG_EN2_BIT = 3;
    localparam int NCH         = 2;

    typedef enum logic [1:0] {
        K_DATA   = 2'd0,
        K_OFFSET = 2'd1,
        K_GAIN   = 2'd2,
        K_NONE   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_WAIT = 2'd2
    } seq_state_e;

    // Map a mode code to the kind of conversion it performs.
    function automatic kind_e mode_kind(input logic [2:0] m);
        case (m)
            MODE_CONT, MODE_SINGL: return K_DATA;
            MODE_OFCAL:            return K_OFFSET;
            MODE_GNCAL:            return K_GAIN;
            default:               return K_NONE;
        endcase
    endfunction

    // True for modes that stop after one pass over the enabled channels.
    function automatic logic mode_once(input logic [2:0] m);
        return (m == MODE_SINGL) || (m == MODE_OFCAL) || (m == MODE_GNCAL);
    endfunction

endpackage

// File: rtl/cseq_timer.sv
// Conversion timer: loads the cycle count chosen by the oversampling
// selector on start and counts down to zero.
// Assumes start is only pulsed while the timer is not running.
module cseq_timer #(
    parameter int CYC_PER_MS = 2,
    parameter int OSR_MS [4] = '{5, 20, 50, 60}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       clear,
    input  logic [1:0] osr,
    output logic       elapsed,
    output logic       running
);

    // Largest duration over the four selector codes.
    function automatic int max_cycles();
        int m = 0;
        for (int i = 0; i < 4; i++)
            if (OSR_MS[i] * CYC_PER_MS > m) m = OSR_MS[i] * CYC_PER_MS;
        return m;
    endfunction

    localparam int MAX_CYC = max_cycles();
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] dur [4];
    logic [CW-1:0] cnt_q;

    // One duration entry per selector code, derived from the parameters.
    for (genvar g = 0; g < 4; g++) begin : g_dur
        assign dur[g] = CW'(OSR_MS[g] * CYC_PER_MS);
    end

    // Down-counter: load on start, clear on abort, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (start)       cnt_q <= dur[osr];
        else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign running = (cnt_q != 0);
    assign elapsed = (cnt_q == 1);

    // R4: an undisturbed running count drops by exactly one per cycle.
    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !clear && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cseq_sched.sv
// Scheduler: holds the configuration word, keeps the set of channels still
// to convert in this pass, and steps through idle / counting / waiting.
// Assumes any configuration write aborts the conversion in flight.
module cseq_sched
    import cseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [4:0] cfg_wdata,
    input  logic       afe_done,
    input  logic       elapsed,
    output logic       timer_start,
    output logic       timer_clear,
    output logic       conv_busy,
    output logic       conv_due,
    output logic       cur_ch,
    output logic       commit,
    output kind_e      cur_kind,
    output logic [2:0] mode,
    output logic [4:0] cfg_rdata
);

    seq_state_e     state_q;
    logic [2:0]     mode_q;
    logic           en1_q, en2_q;
    logic [NCH-1:0] todo_q;
    logic [NCH-1:0] todo_left;
    logic           ch_q;
    logic           go;
    logic           next_ch;

    assign cur_kind    = mode_kind(mode_q);
    assign next_ch     = ~todo_q[0];
    assign go          = (state_q == S_IDLE) && (cur_kind != K_NONE)
                         && (todo_q != 0) && !cfg_wr;
    assign timer_start = go;
    assign timer_clear = cfg_wr;
    assign commit      = (state_q == S_WAIT) && afe_done && !cfg_wr;
    assign todo_left   = todo_q & ~(NCH'(1) << ch_q);

    // Configuration, pass bookkeeping and the conversion state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= MODE_IDLE;
            en1_q   <= 1'b0;
            en2_q   <= 1'b0;
            todo_q  <= '0;
            ch_q    <= 1'b0;
        end else if (cfg_wr) begin
            mode_q  <= cfg_wdata[2:0];
            en1_q   <= cfg_wdata[CFG_EN1_BIT];
            en2_q   <= cfg_wdata[CFG_EN2_BIT];
            todo_q  <= {cfg_wdata[CFG_EN2_BIT], cfg_wdata[CFG_EN1_BIT]};
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (go) begin
                    state_q <= S_RUN;
                    ch_q    <= next_ch;
                end
                S_RUN: if (elapsed) state_q <= S_WAIT;
                S_WAIT: if (afe_done) begin
                    state_q <= S_IDLE;
                    if (todo_left != 0) begin
                        todo_q <= todo_left;
                    end else if (mode_once(mode_q)) begin
                        todo_q <= '0;
                        mode_q <= MODE_IDLE;
                    end else begin
                        todo_q <= {en2_q, en1_q};
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign conv_busy = (state_q == S_RUN) || (state_q == S_WAIT);
    assign conv_due  = (state_q == S_WAIT);
    assign cur_ch    = ch_q;
    assign mode      = mode_q;
    assign cfg_rdata = {en1_q, en2_q, mode_q};

    // R11: writing power-down stops any conversion on the next cycle.
    assert_pdown_aborts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[2:0] == MODE_PDOWN) |=> !conv_busy);

    // R3: a running conversion always targets an enabled channel.
    assert_chan_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> (ch_q ? en2_q : en1_q));

    // R6: finishing the last channel of a one-shot pass returns to idle.
    assert_once_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode_once(mode_q) && todo_left == 0) |=> (mode_q == MODE_IDLE));

endmodule

// File: rtl/cseq_results.sv
// Result bank: per-channel data, offset and gain registers plus the status
// byte. Data loads are dropped while a serial read is in progress.
// Assumes commit is a single-cycle strobe with a stable kind and channel.
module cseq_results
    import cseq_pkg::*;
#(
    parameter int              CODE_W    = 12,
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] OFFS_INIT = 16'h8000,
    parameter logic [DATA_W-1:0] GAIN_INIT = 16'h8000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  kind_e                        kind,
    input  logic                         ch,
    input  logic [CODE_W-1:0]            code,
    input  logic                         rd_busy,
    input  logic [NCH-1:0]               hi_rd,
    input  logic                         pdown_flag,
    output logic [NCH-1:0][DATA_W-1:0]   data,
    output logic [NCH-1:0][DATA_W-1:0]   offs,
    output logic [NCH-1:0][DATA_W-1:0]   gain,
    output logic [7:0]                   status
);

    localparam int PAD = DATA_W - CODE_W;

    logic [DATA_W-1:0] word;
    logic              load_data;
    logic [NCH-1:0]    rdy_n;
    logic              last_q;

    assign word      = {code, {PAD{1'b0}}};
    assign load_data = commit && (kind == K_DATA) && !rd_busy;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (ch == g[0]);

        // Data register and its ready flag for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[g]  <= '0;
                rdy_n[g] <= 1'b1;
            end else if (load_data && hit) begin
                data[g]  <= word;
                rdy_n[g] <= 1'b0;
            end else if (hi_rd[g]) begin
                rdy_n[g] <= 1'b1;
            end
        end

        // Calibration coefficients for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                offs[g] <= OFFS_INIT;
                gain[g] <= GAIN_INIT;
            end else if (commit && hit) begin
                if (kind == K_OFFSET) offs[g] <= word;
                if (kind == K_GAIN)   gain[g] <= word;
            end
        end
    end

    // Last-converted channel indicator.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= 1'b0;
        else if (load_data) last_q <= ch;
    end

    assign status = {pdown_flag, 4'b0000, last_q, rdy_n};

    // R8: a result landing during a serial read leaves data and flags alone.
    assert_drop_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == K_DATA && rd_busy && hi_rd == 0)
        |=> ($stable(data) && $stable(rdy_n) && $stable(last_q)));

    // R7: a kept data result marks its channel ready (active low).
    assert_ready_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_data |=> (rdy_n[$past(ch)] == 1'b0 && last_q == $past(ch)));

    // R9: a high-byte read with no competing load releases the ready flag.
    assert_ready_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd[0] && !(load_data && ch == 1'b0)) |=> rdy_n[0]);

    // R10: calibrations never disturb the data registers.
    assert_cal_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind != K_DATA) |=> $stable(data));

endmodule

// File: rtl/conv_sequencer.sv
// Top: conversion mode sequencer. Ties the scheduler, the conversion timer
// and the result bank together and presents per-channel registers.
// Assumes the front end answers each afe_due with one afe_done strobe.
module conv_sequencer
    import cseq_pkg::*;
#(
    parameter int                CODE_W     = 12,
    parameter int                DATA_W     = 16,
    parameter int                CYC_PER_MS = 2,
    parameter int                OSR_MS [4] = '{5, 20, 50, 60},
    parameter logic [DATA_W-1:0] OFFS_INIT  = 16'h8000,
    parameter logic [DATA_W-1:0] GAIN_INIT  = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [4:0]        cfg_wdata,
    output logic [4:0]        cfg_rdata,
    input  logic [1:0]        osr_sel,
    input  logic              low_supply,
    input  logic              rd_busy,
    input  logic [1:0]        rd_hi_strobe,
    input  logic              afe_done,
    input  logic [CODE_W-1:0] afe_code,
    output logic              afe_busy,
    output logic              afe_due,
    output logic              afe_chan,
    output logic              afe_zero,
    output logic [7:0]        status_byte,
    output logic [DATA_W-1:0] ch1_data,
    output logic [DATA_W-1:0] ch2_data,
    output logic [DATA_W-1:0] ch1_offset,
    output logic [DATA_W-1:0] ch2_offset,
    output logic [DATA_W-1:0] ch1_gain,
    output logic [DATA_W-1:0] ch2_gain
);

    logic                       t_start, t_clear, t_elapsed, t_running;
    logic                       commit;
    kind_e                      kind;
    logic [2:0]                 mode;
    logic [NCH-1:0][DATA_W-1:0] data_a, offs_a, gain_a;

    cseq_sched u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .afe_done    (afe_done),
        .elapsed     (t_elapsed),
        .timer_start (t_start),
        .timer_clear (t_clear),
        .conv_busy   (afe_busy),
        .conv_due    (afe_due),
        .cur_ch      (afe_chan),
        .commit      (commit),
        .cur_kind    (kind),
        .mode        (mode),
        .cfg_rdata   (cfg_rdata)
    );

    cseq_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .OSR_MS     (OSR_MS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .clear   (t_clear),
        .osr     (osr_sel),
        .elapsed (t_elapsed),
        .running (t_running)
    );

    cseq_results #(
        .CODE_W    (CODE_W),
        .DATA_W    (DATA_W),
        .OFFS_INIT (OFFS_INIT),
        .GAIN_INIT (GAIN_INIT)
    ) u_results (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .kind       (kind),
        .ch         (afe_chan),
        .code       (afe_code),
        .rd_busy    (rd_busy),
        .hi_rd      (rd_hi_strobe),
        .pdown_flag ((mode == MODE_PDOWN) || low_supply),
        .data       (data_a),
        .offs       (offs_a),
        .gain       (gain_a),
        .status     (status_byte)
    );

    assign afe_zero   = afe_busy && (kind == K_OFFSET);
    assign ch1_data   = data_a[0];
    assign ch2_data   = data_a[1];
    assign ch1_offset = offs_a[0];
    assign ch2_offset = offs_a[1];
    assign ch1_gain   = gain_a[0];
    assign ch2_gain   = gain_a[1];

    // R4: the timer only runs while the scheduler is counting a conversion.
    assert_timer_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        t_running |-> (afe_busy && !afe_due));

endmodule

// File: tb/tb_conv_sequencer.sv
// Bench for conv_sequencer: a vector table of single conversions, then
// directed tests for reset, modes, alternation, drops and power-down.
module tb_conv_sequencer;

    localparam int CPM = 2;
    localparam int MS_TAB [4] = '{5, 20, 50, 60};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic [4:0]  cfg_rdata;
    logic [1:0]  osr_sel = 2'b00;
    logic        low_supply = 1'b0;
    logic        rd_busy = 1'b0;
    logic [1:0]  rd_hi_strobe = 2'b00;
    logic        afe_done = 1'b0;
    logic [11:0] afe_code = '0;
    logic        afe_busy, afe_due, afe_chan, afe_zero;
    logic [7:0]  status_byte;
    logic [15:0] ch1_data, ch2_data, ch1_offset, ch2_offset, ch1_gain, ch2_gain;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    conv_sequencer #(.CYC_PER_MS(CPM)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .osr_sel(osr_sel), .low_supply(low_supply),
        .rd_busy(rd_busy), .rd_hi_strobe(rd_hi_strobe), .afe_done(afe_done),
        .afe_code(afe_code), .afe_busy(afe_busy), .afe_due(afe_due),
        .afe_chan(afe_chan), .afe_zero(afe_zero), .status_byte(status_byte),
        .ch1_data(ch1_data), .ch2_data(ch2_data), .ch1_offset(ch1_offset),
        .ch2_offset(ch2_offset), .ch1_gain(ch1_gain), .ch2_gain(ch2_gain)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [4:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Wait for a conversion, count its counting phase, then deliver a code.
    task automatic run_conv(input logic [11:0] code, input logic busy_rd,
                            output logic ch, output logic zero, output int cnt);
        int t = 0;
        cnt = 0;
        ch = 1'b0;
        zero = 1'b0;
        while (!afe_busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (!afe_busy) begin
            chk("run_conv start timeout", 0, 1);
        end else begin
            while (!afe_due && cnt < 2000) begin
                cnt++;
                @(negedge clk);
            end
            ch = afe_chan;
            zero = afe_zero;
            afe_done = 1'b1;
            afe_code = code;
            rd_busy = busy_rd;
            @(negedge clk);
            afe_done = 1'b0;
            rd_busy = 1'b0;
        end
    endtask

    task automatic idle_check(input string tag, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (afe_busy) seen = 1'b1;
        end
        chk(tag, {31'd0, seen}, 0);
    endtask

    typedef struct packed {
        logic [1:0]  osr;
        logic        chan;
        logic [11:0] code;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{osr: 2'b00, chan: 1'b0, code: 12'hABC},
        '{osr: 2'b01, chan: 1'b1, code: 12'h123},
        '{osr: 2'b10, chan: 1'b0, code: 12'hFFF},
        '{osr: 2'b11, chan: 1'b1, code: 12'h5A6}
    };

    initial begin
        logic ch, zero;
        int   n;
        logic [15:0] keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {24'd0, status_byte}, 32'h03);
        chk("R1 ch1_data", {16'd0, ch1_data}, 0);
        chk("R1 ch2_data", {16'd0, ch2_data}, 0);
        chk("R1 ch1_offset", {16'd0, ch1_offset}, 32'h8000);
        chk("R1 ch2_gain", {16'd0, ch2_gain}, 32'h8000);
        chk("R1 cfg_rdata", {27'd0, cfg_rdata}, 0);

        // Table: single conversions over every oversampling code (R4, R7, R6, R9)
        for (int i = 0; i < 4; i++) begin
            osr_sel = VECS[i].osr;
            cfg(VECS[i].chan ? 5'b01010 : 5'b10010);
            run_conv(VECS[i].code, 1'b0, ch, zero, n);
            chk("R4 duration", n, MS_TAB[VECS[i].osr] * CPM);
            chk("R3 channel", {31'd0, ch}, {31'd0, VECS[i].chan});
            chk("R7 data", VECS[i].chan ? {16'd0, ch2_data} : {16'd0, ch1_data},
                {16'd0, VECS[i].code, 4'b0000});
            chk("R7 ready low", {31'd0, status_byte[VECS[i].chan]}, 0);
            chk("R7 last chan", {31'd0, status_byte[2]}, {31'd0, VECS[i].chan});
            chk("R6 mode idle", {29'd0, cfg_rdata[2:0]}, 0);
            rd_hi_strobe[VECS[i].chan] = 1'b1;
            @(negedge clk);
            rd_hi_strobe = 2'b00;
            chk("R9 ready back", {31'd0, status_byte[VECS[i].chan]}, 1);
        end
        osr_sel = 2'b00;

        // R2 modes that start nothing
        cfg(5'b11100);  idle_check("R2 mode 100", 30);
        cfg(5'b11111);  idle_check("R2 mode 111", 30);
        cfg(5'b11000);  idle_check("R2 mode 000", 30);
        // R3 no enables
        cfg(5'b00001);  idle_check("R3 no enable", 30);

        // R5 continuous, both channels alternate
        cfg(5'b11001);
        run_conv(12'h111, 1'b0, ch, zero, n); chk("R5 seq0", {31'd0, ch}, 0);
        run_conv(12'h222, 1'b0, ch, zero, n); chk("R5 seq1", {31'd0, ch}, 1);
        run_conv(12'h333, 1'b0, ch, zero, n); chk("R5 seq2", {31'd0, ch}, 0);
        chk("R5 ch1 data", {16'd0, ch1_data}, 32'h3330);
        chk("R5 ch2 data", {16'd0, ch2_data}, 32'h2220);
        cfg(5'b00000);
        // R5 continuous, channel 2 only repeats
        cfg(5'b01001);
        run_conv(12'h444, 1'b0, ch, zero, n); chk("R5 ch2 rep0", {31'd0, ch}, 1);
        run_conv(12'h555, 1'b0, ch, zero, n); chk("R5 ch2 rep1", {31'd0, ch}, 1);
        cfg(5'b00000);
        rd_hi_strobe = 2'b11;
        @(negedge clk);
        rd_hi_strobe = 2'b00;

        // R6 single with both channels: ch1 then ch2, then idle
        cfg(5'b11010);
        run_conv(12'h0F0, 1'b0, ch, zero, n); chk("R6 first ch1", {31'd0, ch}, 0);
        run_conv(12'h00F, 1'b0, ch, zero, n); chk("R6 then ch2", {31'd0, ch}, 1);
        chk("R6 mode cleared", {29'd0, cfg_rdata[2:0]}, 0);
        idle_check("R6 stops", 20);
        rd_hi_strobe = 2'b11;
        @(negedge clk);
        rd_hi_strobe = 2'b00;

        // R8 result during serial read is dropped
        keep = ch1_data;
        cfg(5'b10010);
        run_conv(12'h777, 1'b1, ch, zero, n);
        chk("R8 data kept", {16'd0, ch1_data}, {16'd0, keep});
        chk("R8 ready kept", {31'd0, status_byte[0]}, 1);
        chk("R8 last kept", {31'd0, status_byte[2]}, 1);

        // R10 offset calibration on ch1, gain calibration on ch2
        keep = ch1_data;
        cfg(5'b10101);
        run_conv(12'h321, 1'b0, ch, zero, n);
        chk("R10 zero input", {31'd0, zero}, 1);
        chk("R10 offset loaded", {16'd0, ch1_offset}, 32'h3210);
        chk("R10 data untouched", {16'd0, ch1_data}, {16'd0, keep});
        chk("R10 ready untouched", {31'd0, status_byte[0]}, 1);
        chk("R10 offcal idle", {29'd0, cfg_rdata[2:0]}, 0);
        cfg(5'b01110);
        run_conv(12'h9AB, 1'b0, ch, zero, n);
        chk("R10 gain no zero", {31'd0, zero}, 0);
        chk("R10 gain loaded", {16'd0, ch2_gain}, 32'h9AB0);
        chk("R10 ch2 offset kept", {16'd0, ch2_offset}, 32'h8000);

        // R11 power-down aborts a conversion in flight
        keep = ch1_data;
        cfg(5'b10001);
        while (!afe_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        cfg(5'b10011);
        chk("R11 busy dropped", {31'd0, afe_busy}, 0);
        chk("R11 pdown flag", {31'd0, status_byte[7]}, 1);
        afe_done = 1'b1;
        afe_code = 12'hEEE;
        @(negedge clk);
        afe_done = 1'b0;
        chk("R11 data kept", {16'd0, ch1_data}, {16'd0, keep});
        chk("R11 ready kept", {31'd0, status_byte[0]}, 1);
        chk("R11 spare bits", {28'd0, status_byte[6:3]}, 0);
        cfg(5'b00000);
        chk("R11 pdown clear", {31'd0, status_byte[7]}, 0);
        low_supply = 1'b1;
        @(negedge clk);
        chk("R11 low supply", {31'd0, status_byte[7]}, 1);
        low_supply = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule